// File: doc/BRIEF.md
# Activity-Toggle GPIO Pin Controller

This block owns the five general-purpose pads of a two-channel serial bridge. Three pads belong to the standard channel and two to the enhanced channel. Each channel is switched as a whole between GPIO mode and modem mode. In modem mode the pads of that channel carry the drive value and output-enable supplied by the modem-control logic. In GPIO mode every pad takes its behaviour from a two-bit kind field. The kinds are input, open-drain output and push-pull output. An alternate-function bit per pad can instead connect the pad to an activity indicator or to a line-driver enable.

Each activity indicator sits high while its direction of its channel is idle. It blinks with a fixed half-period of `TOGGLE_HALF` clock cycles while that direction is busy. Each indicator is a three-state machine:
- `TG_IDLE` drives the output high. It moves to `TG_RUN_LOW` when busy is seen.
- `TG_RUN_LOW` drives the output low. When its half-period expires it moves to `TG_RUN_HIGH` if still busy, or to `TG_IDLE` otherwise.
- `TG_RUN_HIGH` drives the output high. It moves to `TG_IDLE` as soon as busy is gone, or to `TG_RUN_LOW` when its half-period expires while still busy.

The RS-485 driver enable of the enhanced channel is a two-state machine:
- `DE_OFF` moves to `DE_ON` when the transmit-frame flag is seen.
- `DE_ON` moves back to `DE_OFF` when the flag is gone.

The pad readback passes every pad through a two-flop synchronizer.

Pad roles follow the position of the pad within its channel:
- Pad 0 of a channel is its transmit indicator.
- Pad 1 is its receive indicator. On the enhanced channel, pad 1 can be the RS-485 enable instead.
- Pad 2 of the standard channel has no alternate role.

Pads 0 to 2 are the standard channel and pads 3 to 4 are the enhanced channel.

Top module: `bridge_pin_ctl`

## Requirements
- R1: After reset the output register holds all ones, every activity indicator is high and the RS-485 enable is low. With every pad set to push-pull and no alternate, all pads drive 1.
- R2: When a channel's mode bit is 1 (modem), each of its pads drives `modem_out` and `modem_oe` at the same index. The other channel is unaffected.
- R3: In GPIO mode the kind field `cfg_kind[2i+1:2i]` selects the pad behaviour:
  - 00 or 11 (input): `pad_oe`=0 and `pad_out`=0.
  - 01 (open-drain): `pad_out`=0 and `pad_oe` is the inverse of the register bit.
  - 10 (push-pull): `pad_oe`=1 and `pad_out` is the register bit.
- R4: A write (`gpio_wr`=1 for one cycle) updates only the register bits of pads that are GPIO outputs. Bits of pads that are inputs, in an alternate role or in a modem-mode channel keep their value.
- R5: `gpio_rd` equals `pad_in` as it was two clock edges earlier.
- R6: In GPIO mode with `cfg_alt` set on pad 0 of a channel, the pad drives that channel's transmit indicator push-pull. While the channel is idle the indicator is 1.
- R7: The indicator goes low on the edge that first sees busy high. It then alternates, spending exactly `TOGGLE_HALF` cycles low and `TOGGLE_HALF` cycles high, for as long as busy stays high.
- R8: When busy ends during a low phase, that low phase completes and the output then stays high. When busy ends during a high phase, the output stays high.
- R9: With `enh_pin1_rs485`=1 and `cfg_alt[4]`=1 in GPIO mode, pad 4 drives the RS-485 enable push-pull, whatever its kind. The enable equals `enh_tx_frame` delayed by one cycle.
- R10: `cfg_alt[2]` is ignored: standard pad 2 always behaves as a plain GPIO.
- R11: With `cfg_alt` set on pad 1 of a channel, and the RS-485 role not chosen for the enhanced channel, the pad drives that channel's receive indicator with the R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_modem | input | 1 | Standard channel mode: 1 = modem, 0 = GPIO |
| enh_modem | input | 1 | Enhanced channel mode: 1 = modem, 0 = GPIO |
| cfg_kind | input | 2*NPIN | Kind field per pad (00/11 input, 01 open-drain, 10 push-pull) |
| cfg_alt | input | NPIN | Alternate-role enable per pad |
| enh_pin1_rs485 | input | 1 | Enhanced pad 1 alternate: 1 = RS-485 enable, 0 = receive indicator |
| gpio_wr | input | 1 | Output-register write strobe |
| gpio_wdata | input | NPIN | Output-register write data |
| gpio_rd | output | NPIN | Synchronized pad readback |
| tx_busy | input | 2 | Transmit in progress, bit 0 standard, bit 1 enhanced |
| rx_busy | input | 2 | Receive in progress, bit 0 standard, bit 1 enhanced |
| enh_tx_frame | input | 1 | Enhanced transmitter frame active, from first bit to last stop bit |
| modem_out | input | NPIN | Modem-control drive value per pad |
| modem_oe | input | NPIN | Modem-control output-enable per pad |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad output-enable |

## Verification
The assertions take for granted that the busy flags, the frame flag, the pad inputs and the configuration inputs change only between clock edges. In particular they assume that `pad_in` is a synchronous signal, so that the two-cycle readback relation holds exactly. The bench drives every input one time unit after a rising edge and keeps it stable across the next edge, which holds to that assumption. The bench changes the configuration only while no indicator is mid-pattern on the pad being checked, so that each expected value follows from the active configuration alone.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        KIND_IN  = 2'b00,
        KIND_OD  = 2'b01,
        KIND_PP  = 2'b10,
        KIND_IN2 = 2'b11
    } pin_kind_e;

    typedef enum logic [1:0] {
        TG_IDLE     = 2'd0,
        TG_RUN_LOW  = 2'd1,
        TG_RUN_HIGH = 2'd2
    } tog_state_e;

    typedef enum logic {
        DE_OFF = 1'b0,
        DE_ON  = 1'b1
    } de_state_e;

    typedef enum logic [1:0] {
        SRC_GPIO  = 2'd0,
        SRC_ALT   = 2'd1,
        SRC_MODEM = 2'd2
    } pin_src_e;
endpackage

// File: rtl/bpc_activity_toggle.sv
module bpc_activity_toggle
    import bpc_pkg::*;
#(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic tog_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    tog_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          expire;

    assign expire = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TG_IDLE: begin
                cnt_d = '0;
                if (busy) state_d = TG_RUN_LOW;
            end
            TG_RUN_LOW: begin
                if (expire) begin
                    cnt_d   = '0;
                    state_d = busy ? TG_RUN_HIGH : TG_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TG_RUN_HIGH: begin
                if (!busy) begin
                    cnt_d   = '0;
                    state_d = TG_IDLE;
                end else if (expire) begin
                    cnt_d   = '0;
                    state_d = TG_RUN_LOW;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = TG_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        tog_o = (state_q != TG_RUN_LOW);
    end
endmodule

// File: rtl/bpc_rs485_enable.sv
module bpc_rs485_enable
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    output logic de_o
);
    timeunit 1ns;
    timeprecision 100ps;

    de_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DE_OFF: if (frame)  state_d = DE_ON;
            DE_ON:  if (!frame) state_d = DE_OFF;
            default: state_d = DE_OFF;
        endcase
    end

    always_comb begin
        de_o = (state_q == DE_ON);
    end
endmodule

// File: rtl/bpc_in_sync.sv
module bpc_in_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/bpc_pin_drive.sv
module bpc_pin_drive
    import bpc_pkg::*;
#(
    parameter bit HAS_ALT = 1'b1
) (
    input  logic       modem_mode,
    input  logic [1:0] kind,
    input  logic       alt_en,
    input  logic       alt_val,
    input  logic       gpio_val,
    input  logic       modem_out,
    input  logic       modem_oe,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       owned
);
    timeunit 1ns;
    timeprecision 100ps;

    pin_src_e  src;
    pin_kind_e kind_e;
    logic      alt_active;

    assign kind_e     = pin_kind_e'(kind);
    assign alt_active = HAS_ALT && alt_en;

    always_comb begin
        if (modem_mode)      src = SRC_MODEM;
        else if (alt_active) src = SRC_ALT;
        else                 src = SRC_GPIO;
    end

    assign owned = (src == SRC_GPIO) && ((kind_e == KIND_OD) || (kind_e == KIND_PP));

    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        unique case (src)
            SRC_MODEM: begin
                pad_out = modem_out;
                pad_oe  = modem_oe;
            end
            SRC_ALT: begin
                pad_out = alt_val;
                pad_oe  = 1'b1;
            end
            SRC_GPIO: begin
                unique case (kind_e)
                    KIND_OD: begin
                        pad_out = 1'b0;
                        pad_oe  = !gpio_val;
                    end
                    KIND_PP: begin
                        pad_out = gpio_val;
                        pad_oe  = 1'b1;
                    end
                    KIND_IN, KIND_IN2: begin
                        pad_out = 1'b0;
                        pad_oe  = 1'b0;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bridge_pin_ctl.sv
module bridge_pin_ctl
    import bpc_pkg::*;
#(
    parameter  int STD_PINS    = 3,
    parameter  int ENH_PINS    = 2,
    parameter  int TOGGLE_HALF = 8,
    localparam int NPIN        = STD_PINS + ENH_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_modem,
    input  logic              enh_modem,
    input  logic [2*NPIN-1:0] cfg_kind,
    input  logic [NPIN-1:0]   cfg_alt,
    input  logic              enh_pin1_rs485,
    input  logic              gpio_wr,
    input  logic [NPIN-1:0]   gpio_wdata,
    output logic [NPIN-1:0]   gpio_rd,
    input  logic [1:0]        tx_busy,
    input  logic [1:0]        rx_busy,
    input  logic              enh_tx_frame,
    input  logic [NPIN-1:0]   modem_out,
    input  logic [NPIN-1:0]   modem_oe,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NCH-1:0]  tx_tog;
    logic [NCH-1:0]  rx_tog;
    logic            rs485_de;
    logic [NPIN-1:0] out_q;
    logic [NPIN-1:0] owned;

    // activity indicators, one pair per channel
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bpc_activity_toggle #(.HALF(TOGGLE_HALF)) u_tx (
            .clk   (clk),
            .rst_n (rst_n),
            .busy  (tx_busy[c]),
            .tog_o (tx_tog[c])
        );
        bpc_activity_toggle #(.HALF(TOGGLE_HALF)) u_rx (
            .clk   (clk),
            .rst_n (rst_n),
            .busy  (rx_busy[c]),
            .tog_o (rx_tog[c])
        );
    end

    bpc_rs485_enable u_de (
        .clk   (clk),
        .rst_n (rst_n),
        .frame (enh_tx_frame),
        .de_o  (rs485_de)
    );

    bpc_in_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (gpio_rd)
    );

    // output register: only pads currently owned by GPIO take the write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_q <= '1;
        else if (gpio_wr) out_q <= (out_q & ~owned) | (gpio_wdata & owned);
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        localparam int  PORT  = (i >= STD_PINS) ? 1 : 0;
        localparam int  LOCAL = (PORT == 1) ? i - STD_PINS : i;
        localparam bit  HAS_A = (LOCAL < 2);

        logic alt_val;
        if (LOCAL == 0) begin : g_tx
            assign alt_val = tx_tog[PORT];
        end else if (LOCAL == 1 && PORT == 1) begin : g_rx_de
            assign alt_val = enh_pin1_rs485 ? rs485_de : rx_tog[PORT];
        end else if (LOCAL == 1) begin : g_rx
            assign alt_val = rx_tog[PORT];
        end else begin : g_none
            assign alt_val = 1'b0;
        end

        bpc_pin_drive #(.HAS_ALT(HAS_A)) u_drv (
            .modem_mode (PORT == 1 ? enh_modem : std_modem),
            .kind       (cfg_kind[2*i +: 2]),
            .alt_en     (cfg_alt[i]),
            .alt_val    (alt_val),
            .gpio_val   (out_q[i]),
            .modem_out  (modem_out[i]),
            .modem_oe   (modem_oe[i]),
            .pad_out    (pad_out[i]),
            .pad_oe     (pad_oe[i]),
            .owned      (owned[i])
        );
    end
endmodule

// File: rtl/bridge_pin_ctl_chk.sv
module bridge_pin_ctl_chk #(
    parameter int STD_PINS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                std_modem,
    input logic                enh_modem,
    input logic [1:0]          kind_p2,
    input logic                alt_p4,
    input logic                enh_pin1_rs485,
    input logic                enh_tx_frame,
    input logic                tx_busy0,
    input logic                tx_tog0,
    input logic                de_i,
    input logic [STD_PINS-1:0] modem_out_std,
    input logic [STD_PINS-1:0] modem_oe_std,
    input logic [4:0]          pad_in,
    input logic [4:0]          gpio_rd,
    input logic [4:0]          pad_out,
    input logic [4:0]          pad_oe
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_MODEM_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        std_modem |-> (pad_out[STD_PINS-1:0] == modem_out_std && pad_oe[STD_PINS-1:0] == modem_oe_std)); // R2

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!std_modem && (kind_p2 == 2'b00 || kind_p2 == 2'b11)) |-> !pad_oe[2]); // R3

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!std_modem && kind_p2 == 2'b01) |-> !pad_out[2]); // R3

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (gpio_rd == $past(pad_in, 2))); // R5

    AST_TOGGLE_FALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_tog0) |-> $past(tx_busy0)); // R7

    AST_DE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> (de_i == $past(enh_tx_frame))); // R9

    AST_DE_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_modem && alt_p4 && enh_pin1_rs485) |-> (pad_oe[4] && pad_out[4] == de_i)); // R9
endmodule

bind bridge_pin_ctl bridge_pin_ctl_chk #(.STD_PINS(STD_PINS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .std_modem      (std_modem),
    .enh_modem      (enh_modem),
    .kind_p2        (cfg_kind[5:4]),
    .alt_p4         (cfg_alt[4]),
    .enh_pin1_rs485 (enh_pin1_rs485),
    .enh_tx_frame   (enh_tx_frame),
    .tx_busy0       (tx_busy[0]),
    .tx_tog0        (tx_tog[0]),
    .de_i           (rs485_de),
    .modem_out_std  (modem_out[STD_PINS-1:0]),
    .modem_oe_std   (modem_oe[STD_PINS-1:0]),
    .pad_in         (pad_in[4:0]),
    .gpio_rd        (gpio_rd[4:0]),
    .pad_out        (pad_out[4:0]),
    .pad_oe         (pad_oe[4:0])
);

// File: tb/bridge_pin_ctl_test.sv
module bridge_pin_ctl_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [1:0] IN = 2'b00, OD = 2'b01, PP = 2'b10;
    localparam int OBS_OUT = 0, OBS_OE = 1, OBS_RD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_modem = 1'b0, enh_modem = 1'b0;
    logic [9:0] cfg_kind = '0;
    logic [4:0] cfg_alt = '0;
    logic       enh_pin1_rs485 = 1'b0;
    logic       gpio_wr = 1'b0;
    logic [4:0] gpio_wdata = '0;
    logic [4:0] gpio_rd;
    logic [1:0] tx_busy = '0, rx_busy = '0;
    logic       enh_tx_frame = 1'b0;
    logic [4:0] modem_out = '0, modem_oe = '0, pad_in = '0;
    logic [4:0] pad_out, pad_oe;

    int  checks = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bridge_pin_ctl uut (
        .clk(clk), .rst_n(rst_n), .std_modem(std_modem), .enh_modem(enh_modem),
        .cfg_kind(cfg_kind), .cfg_alt(cfg_alt), .enh_pin1_rs485(enh_pin1_rs485),
        .gpio_wr(gpio_wr), .gpio_wdata(gpio_wdata), .gpio_rd(gpio_rd),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .enh_tx_frame(enh_tx_frame),
        .modem_out(modem_out), .modem_oe(modem_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct {
        int         sel;
        logic [4:0] exp;
        logic [4:0] mask;
        string      req;
    } item_t;

    item_t sb[$];

    task automatic expect_obs(input int sel, input logic [4:0] exp,
                              input logic [4:0] mask, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.mask = mask; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_reg(input logic [4:0] d);
        gpio_wdata = d;
        gpio_wr    = 1'b1;
        step(1);
        gpio_wr    = 1'b0;
    endtask

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [4:0] act;
            it = sb.pop_front();
            case (it.sel)
                OBS_OUT: act = pad_out;
                OBS_OE:  act = pad_oe;
                default: act = gpio_rd;
            endcase
            checks++;
            if ((act & it.mask) != (it.exp & it.mask)) begin
                bad++;
                $display("FAIL %s: obs=%0d actual=%b expected=%b mask=%b",
                         it.req, it.sel, act, it.exp, it.mask);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        cfg_kind = {PP, PP, PP, PP, PP};
        expect_obs(OBS_OUT, 5'b11111, 5'b11111, "R1 reg all ones");
        expect_obs(OBS_OE,  5'b11111, 5'b11111, "R1 push-pull oe");
        step(1);
        cfg_alt = 5'b11011;
        expect_obs(OBS_OUT, 5'b11011, 5'b11011, "R1 R6 indicators idle high");
        step(1);
        enh_pin1_rs485 = 1'b1;
        expect_obs(OBS_OUT, 5'b00000, 5'b10000, "R1 rs485 enable low");
        step(1);
        cfg_alt = '0; enh_pin1_rs485 = 1'b0;

        // R3 pad kinds
        cfg_kind = {PP, OD, PP, OD, IN};
        write_reg(5'b00000);
        expect_obs(OBS_OUT, 5'b00000, 5'b11111, "R3 kinds low");
        expect_obs(OBS_OE,  5'b11110, 5'b11111, "R3 kinds low oe");
        step(1);
        write_reg(5'b11111);
        expect_obs(OBS_OUT, 5'b10100, 5'b11111, "R3 kinds high");
        expect_obs(OBS_OE,  5'b10100, 5'b11111, "R3 kinds high oe");
        step(1);

        // R4 writes ignored for input, alternate and modem pads
        cfg_kind = {PP, PP, PP, PP, IN};
        cfg_alt = 5'b00010; enh_modem = 1'b1;
        write_reg(5'b00000);
        cfg_kind = {PP, PP, PP, PP, PP};
        cfg_alt = '0; enh_modem = 1'b0;
        expect_obs(OBS_OUT, 5'b11011, 5'b11111, "R4 ignored writes");
        step(1);

        // R10 alternate bit on standard pad 2 ignored
        cfg_alt = 5'b00100;
        write_reg(5'b11111);
        expect_obs(OBS_OUT, 5'b00100, 5'b00100, "R10 pad2 gpio high");
        expect_obs(OBS_OE,  5'b00100, 5'b00100, "R10 pad2 oe");
        step(1);
        write_reg(5'b00000);
        expect_obs(OBS_OUT, 5'b00000, 5'b00100, "R10 pad2 gpio low");
        step(1);
        cfg_alt = '0;

        // R2 modem mode
        modem_out = 5'b10101; modem_oe = 5'b01011;
        std_modem = 1'b1;
        expect_obs(OBS_OUT, 5'b00101, 5'b11111, "R2 std modem out");
        expect_obs(OBS_OE,  5'b11011, 5'b11111, "R2 std modem oe");
        step(1);
        std_modem = 1'b0; enh_modem = 1'b1;
        expect_obs(OBS_OUT, 5'b10000, 5'b11111, "R2 enh modem out");
        expect_obs(OBS_OE,  5'b01111, 5'b11111, "R2 enh modem oe");
        step(1);
        enh_modem = 1'b0; modem_out = '0; modem_oe = '0;

        // R5 input synchronizer
        pad_in = 5'b10110;
        step(1);
        expect_obs(OBS_RD, 5'b00000, 5'b11111, "R5 one edge");
        step(1);
        expect_obs(OBS_RD, 5'b10110, 5'b11111, "R5 two edges");
        pad_in = 5'b01001;
        step(2);
        expect_obs(OBS_RD, 5'b01001, 5'b11111, "R5 second pattern");

        // R6 R7 R8 transmit indicator on standard pad 0
        cfg_alt = 5'b00001;
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R6 tx idle high");
        expect_obs(OBS_OE,  5'b00001, 5'b00001, "R6 push-pull");
        tx_busy = 2'b01;
        step(1);
        expect_obs(OBS_OUT, 5'b00000, 5'b00001, "R7 first low");
        step(7);
        expect_obs(OBS_OUT, 5'b00000, 5'b00001, "R7 low end");
        step(1);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R7 high start");
        step(7);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R7 high end");
        step(1);
        expect_obs(OBS_OUT, 5'b00000, 5'b00001, "R7 second low");
        tx_busy = 2'b00;
        step(3);
        expect_obs(OBS_OUT, 5'b00000, 5'b00001, "R8 low phase completes");
        step(4);
        expect_obs(OBS_OUT, 5'b00000, 5'b00001, "R8 last low cycle");
        step(1);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R8 back high");
        step(5);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R8 stays high");
        tx_busy = 2'b01;
        step(9);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R8 in high phase");
        tx_busy = 2'b00;
        step(1);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R8 stop in high");
        step(4);
        expect_obs(OBS_OUT, 5'b00001, 5'b00001, "R8 no late low");
        step(1);

        // R11 receive indicators
        cfg_alt = 5'b10010;
        rx_busy = 2'b10;
        step(1);
        expect_obs(OBS_OUT, 5'b00010, 5'b10010, "R11 enh rx low, std rx high");
        rx_busy = 2'b00;
        step(7);
        expect_obs(OBS_OUT, 5'b00010, 5'b10010, "R11 low holds");
        step(1);
        expect_obs(OBS_OUT, 5'b10010, 5'b10010, "R11 back high");
        step(1);

        // R9 RS-485 enable on enhanced pad 1, pad kind input
        cfg_alt = 5'b10000; enh_pin1_rs485 = 1'b1;
        cfg_kind = {IN, PP, PP, PP, PP};
        enh_tx_frame = 1'b1;
        expect_obs(OBS_OUT, 5'b00000, 5'b10000, "R9 before edge");
        expect_obs(OBS_OE,  5'b10000, 5'b10000, "R9 driven");
        step(1);
        expect_obs(OBS_OUT, 5'b10000, 5'b10000, "R9 asserted");
        enh_tx_frame = 1'b0;
        step(1);
        expect_obs(OBS_OUT, 5'b00000, 5'b10000, "R9 released");
        step(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule